// File: doc/BRIEF.md
# Strap-Selected Management Register Window

This block sits between a parallel management access port and a device's internal register space. A four-bit strap, captured once after reset, selects how the device presents itself. A zero strap selects single-chip mode. In that mode every management access, whatever its device number, goes straight through to the internal request/acknowledge port with its device, register, direction and data unchanged. The management side is answered once the internal side acknowledges.

A nonzero strap selects multi-chip mode, which lets several devices share one management bus. Only the device number formed by the strap shifted left one place, with bit 0 zero, is answered, and only at two register offsets: a command register and a data register. Writing a valid command starts one internal access that runs for several cycles. A busy flag shows while it runs and drops by itself when the internal port acknowledges. A read command leaves its result in the data register. A write command delivers the data register's contents. All other accesses get no claim and read as all ones.

Top module: `mgmt_window`

## Requirements
- R1: The strap is captured in the first clock after reset is released and then held until the next reset. Strap changes after that capture have no effect on the mode or on the answered address.
- R2: With a zero strap, every access to any device 0..31 and any register 0..31 is forwarded to the internal port with the same device, register, direction and write data. `intReq` stays high with a stable payload until `intAck`. `mgmtAck` pulses with `mgmtHit`=1 the cycle after `intAck`, and carries the internal read data for a read or zero for a write.
- R3: With a nonzero strap S, only accesses with device number {S,0} at register 0 (command) or 1 (data) are claimed. Every other access is acknowledged with `mgmtHit`=0 and `mgmtRdata`=16'hFFFF. It changes no state and starts no internal access.
- R4: Command word layout: bit 15 start/busy, bit 12 mode (1 = Clause 22 style), bits 11:10 opcode (01 write, 10 read), bits 9:5 internal device, bits 4:0 internal register.
- R5: A valid command written while idle sets busy and starts one internal access. Busy reads back as 1 until the internal acknowledge, and clears by itself after it.
- R6: For a read command, the internal read result is in the data register by the time busy reads back 0.
- R7: For a write command, the data register value held when the command was accepted is sent to the device and register named in the command.
- R8: A command write that arrives while busy is set is ignored. The stored command fields are unchanged and no second internal access starts.
- R9: A command write with bit 15 clear, mode bit 0, or opcode 00 or 11 is ignored. Busy stays clear, no internal access starts, and the stored fields are unchanged.
- R10: A command register read returns the live busy bit in bit 15 above bits 14:0 of the last accepted command. After reset it reads 16'h0000, and the data register also reads 16'h0000.
- R11: In multi-chip mode each management access is acknowledged exactly one cycle after its request cycle. A busy internal access does not delay this.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| strap | input | 4 | Address strap, sampled once after reset |
| mgmtReq | input | 1 | One-cycle management access strobe |
| mgmtWrite | input | 1 | 1 = write access, 0 = read access |
| mgmtDev | input | 5 | Management device number |
| mgmtReg | input | 5 | Management register number |
| mgmtWdata | input | 16 | Management write data |
| mgmtAck | output | 1 | One-cycle response strobe |
| mgmtHit | output | 1 | Access was claimed by this device |
| mgmtRdata | output | 16 | Response read data |
| intReq | output | 1 | Internal access request, held until acknowledge |
| intWrite | output | 1 | Internal access direction |
| intDev | output | 5 | Internal device number |
| intReg | output | 5 | Internal register number |
| intWdata | output | 16 | Internal write data |
| intAck | input | 1 | Internal access acknowledge pulse |
| intRdata | input | 16 | Internal read data, valid with intAck |

## Verification
The bench targets the address filter at odd, neighbouring and out-of-window offsets. A filter that decoded the wrong bit would claim those accesses or let a stray write corrupt the data register. It reads the command register in the middle of an internal access and again after it. A busy bit that never cleared, or that cleared before the read data landed, shows up as a wrong busy value or stale data. Overlapping and malformed command writes are checked through the stored fields and the internal request count. A design that accepted them would start extra accesses or overwrite the fields. Last, the strap is changed after reset to show that a design which sampled it continuously would switch modes.

// File: rtl/win_pkg.sv
package win_pkg;
  localparam int STRAP_W  = 4;
  localparam int DEV_W    = STRAP_W + 1;
  localparam int REG_W    = 5;
  localparam int DATA_W   = 16;
  localparam int BUSY_BIT = 15;
  localparam int MODE_BIT = 12;
  localparam int OP_LSB   = 10;
  localparam int DEV_LSB  = 5;
  localparam int REG_LSB  = 0;
  localparam int CMD_OFS  = 0;
  localparam int DATA_OFS = 1;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;

  typedef enum logic [2:0] {
    RSEL_NONE,
    RSEL_CMD,
    RSEL_DATA,
    RSEL_INT,
    RSEL_ZERO
  } respSel_e;

  typedef struct packed {
    logic     loadCmd;
    logic     loadDataHost;
    logic     windowDone;
    logic     startDirect;
    logic     startInd;
    logic     respFire;
    logic     respHit;
    respSel_e respSel;
  } winStrobe_t;
endpackage

// File: rtl/win_ctrl.sv
module win_ctrl
  import win_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [STRAP_W-1:0] strap,
  input  logic               mgmtReq,
  input  logic               mgmtWrite,
  input  logic [DEV_W-1:0]   mgmtDev,
  input  logic [REG_W-1:0]   mgmtReg,
  input  logic [3:0]         cmdCtl,
  input  logic               intAck,
  output logic               intReq,
  output logic               busy,
  output logic               singleMode,
  output logic               strapLoaded,
  output logic [STRAP_W-1:0] strapQ,
  output winStrobe_t         strb
);
  typedef enum logic [1:0] {ST_IDLE, ST_DIRECT, ST_WINDOW} state_e;

  state_e state, stateNext;
  logic   ownDev, regIsCmd, regIsData, cmdOk;

  // Strap is taken once, on the first clock after reset release.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strapQ      <= '0;
      strapLoaded <= 1'b0;
    end else if (!strapLoaded) begin
      strapQ      <= strap;
      strapLoaded <= 1'b1;
    end
  end

  always_comb begin
    singleMode = (strapQ == '0);
    ownDev     = (mgmtDev == {strapQ, 1'b0});
    regIsCmd   = (mgmtReg == REG_W'(CMD_OFS));
    regIsData  = (mgmtReg == REG_W'(DATA_OFS));
    // cmdCtl = {start, mode, opcode[1:0]}
    cmdOk      = cmdCtl[3] && cmdCtl[2] &&
                 ((cmdCtl[1:0] == OP_WRITE) || (cmdCtl[1:0] == OP_READ));
    intReq     = (state != ST_IDLE);
    busy       = (state == ST_WINDOW);
  end

  always_comb begin
    strb         = '0;
    strb.respSel = RSEL_NONE;
    if (strapLoaded && mgmtReq) begin
      if (singleMode) begin
        if (state == ST_IDLE) strb.startDirect = 1'b1;
      end else begin
        strb.respFire = 1'b1;
        if (ownDev && (regIsCmd || regIsData)) begin
          strb.respHit = 1'b1;
          if (mgmtWrite) begin
            strb.respSel = RSEL_ZERO;
            if (regIsCmd) begin
              if (!busy && cmdOk) begin
                strb.loadCmd  = 1'b1;
                strb.startInd = 1'b1;
              end
            end else begin
              strb.loadDataHost = 1'b1;
            end
          end else begin
            strb.respSel = regIsCmd ? RSEL_CMD : RSEL_DATA;
          end
        end
      end
    end
    if (state == ST_DIRECT && intAck) begin
      strb.respFire = 1'b1;
      strb.respHit  = 1'b1;
      strb.respSel  = RSEL_INT;
    end
    if (state == ST_WINDOW && intAck) strb.windowDone = 1'b1;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (strb.startDirect)   stateNext = ST_DIRECT;
        else if (strb.startInd) stateNext = ST_WINDOW;
      end
      ST_DIRECT, ST_WINDOW: if (intAck) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/win_dpath.sv
module win_dpath
  import win_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  winStrobe_t        strb,
  input  logic              busy,
  input  logic              mgmtWrite,
  input  logic [DEV_W-1:0]  mgmtDev,
  input  logic [REG_W-1:0]  mgmtReg,
  input  logic [DATA_W-1:0] mgmtWdata,
  input  logic [DATA_W-1:0] intRdata,
  output logic              mgmtAck,
  output logic              mgmtHit,
  output logic [DATA_W-1:0] mgmtRdata,
  output logic              intWrite,
  output logic [DEV_W-1:0]  intDev,
  output logic [REG_W-1:0]  intReg,
  output logic [DATA_W-1:0] intWdata,
  output logic [DATA_W-2:0] cmdQ,
  output logic [DATA_W-1:0] dataQ
);
  logic [DATA_W-1:0] respData;

  always_comb begin
    case (strb.respSel)
      RSEL_CMD:  respData = {busy, cmdQ};
      RSEL_DATA: respData = dataQ;
      RSEL_INT:  respData = intWrite ? '0 : intRdata;
      RSEL_ZERO: respData = '0;
      default:   respData = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ      <= '0;
      dataQ     <= '0;
      intWrite  <= 1'b0;
      intDev    <= '0;
      intReg    <= '0;
      intWdata  <= '0;
      mgmtAck   <= 1'b0;
      mgmtHit   <= 1'b0;
      mgmtRdata <= '0;
    end else begin
      mgmtAck <= strb.respFire;
      if (strb.respFire) begin
        mgmtHit   <= strb.respHit;
        mgmtRdata <= respData;
      end
      if (strb.loadCmd) cmdQ <= mgmtWdata[DATA_W-2:0];
      // A finishing internal read takes priority over a host data write.
      if (strb.windowDone && !intWrite) dataQ <= intRdata;
      else if (strb.loadDataHost)       dataQ <= mgmtWdata;
      if (strb.startDirect) begin
        intWrite <= mgmtWrite;
        intDev   <= mgmtDev;
        intReg   <= mgmtReg;
        intWdata <= mgmtWdata;
      end else if (strb.startInd) begin
        intWrite <= (mgmtWdata[OP_LSB +: 2] == OP_WRITE);
        intDev   <= mgmtWdata[DEV_LSB +: DEV_W];
        intReg   <= mgmtWdata[REG_LSB +: REG_W];
        intWdata <= dataQ;
      end
    end
  end
endmodule

// File: rtl/mgmt_window.sv
module mgmt_window
  import win_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [STRAP_W-1:0] strap,
  input  logic               mgmtReq,
  input  logic               mgmtWrite,
  input  logic [DEV_W-1:0]   mgmtDev,
  input  logic [REG_W-1:0]   mgmtReg,
  input  logic [DATA_W-1:0]  mgmtWdata,
  output logic               mgmtAck,
  output logic               mgmtHit,
  output logic [DATA_W-1:0]  mgmtRdata,
  output logic               intReq,
  output logic               intWrite,
  output logic [DEV_W-1:0]   intDev,
  output logic [REG_W-1:0]   intReg,
  output logic [DATA_W-1:0]  intWdata,
  input  logic               intAck,
  input  logic [DATA_W-1:0]  intRdata
);
  winStrobe_t         strb;
  logic               busy, singleMode, strapLoaded;
  logic [STRAP_W-1:0] strapQ;
  logic [DATA_W-2:0]  cmdQ;
  logic [DATA_W-1:0]  dataQ;
  logic [3:0]         cmdCtl;

  assign cmdCtl = {mgmtWdata[BUSY_BIT], mgmtWdata[MODE_BIT], mgmtWdata[OP_LSB +: 2]};

  win_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .strap(strap),
    .mgmtReq(mgmtReq), .mgmtWrite(mgmtWrite), .mgmtDev(mgmtDev),
    .mgmtReg(mgmtReg), .cmdCtl(cmdCtl), .intAck(intAck),
    .intReq(intReq), .busy(busy), .singleMode(singleMode),
    .strapLoaded(strapLoaded), .strapQ(strapQ), .strb(strb)
  );

  win_dpath uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy),
    .mgmtWrite(mgmtWrite), .mgmtDev(mgmtDev), .mgmtReg(mgmtReg),
    .mgmtWdata(mgmtWdata), .intRdata(intRdata),
    .mgmtAck(mgmtAck), .mgmtHit(mgmtHit), .mgmtRdata(mgmtRdata),
    .intWrite(intWrite), .intDev(intDev), .intReg(intReg),
    .intWdata(intWdata), .cmdQ(cmdQ), .dataQ(dataQ)
  );
endmodule

// File: rtl/win_checker.sv
module win_checker
  import win_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               mgmtReq,
  input logic               mgmtWrite,
  input logic [DEV_W-1:0]   mgmtDev,
  input logic [REG_W-1:0]   mgmtReg,
  input logic               mgmtAck,
  input logic               mgmtHit,
  input logic [DATA_W-1:0]  mgmtRdata,
  input logic               intReq,
  input logic               intWrite,
  input logic [DEV_W-1:0]   intDev,
  input logic [REG_W-1:0]   intReg,
  input logic [DATA_W-1:0]  intWdata,
  input logic               intAck,
  input logic [DATA_W-1:0]  intRdata,
  input logic               busy,
  input logic               singleMode,
  input logic               strapLoaded,
  input logic [STRAP_W-1:0] strapQ,
  input logic [DATA_W-2:0]  cmdQ,
  input logic [DATA_W-1:0]  dataQ
);
  assert_strap_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    strapLoaded |=> strapLoaded && $stable(strapQ));

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    intReq && !intAck |=> intReq && $stable(intDev) && $stable(intReg) &&
                          $stable(intWdata) && $stable(intWrite));

  assert_direct_ack_R2: assert property (@(posedge clk) disable iff (!rstN)
    mgmtAck && singleMode |-> $past(intAck) && mgmtHit);

  assert_miss_ones_R3: assert property (@(posedge clk) disable iff (!rstN)
    mgmtAck && !mgmtHit |-> mgmtRdata == 16'hFFFF);

  assert_window_start_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intReq) && !singleMode |->
      busy && $past(mgmtReq && mgmtWrite && mgmtReg == REG_W'(CMD_OFS) &&
                    mgmtDev == {strapQ, 1'b0}));

  assert_read_load_R6: assert property (@(posedge clk) disable iff (!rstN)
    intReq && intAck && !intWrite && !singleMode |=> dataQ == $past(intRdata));

  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy && mgmtReq && mgmtWrite |=> $stable(cmdQ));

  assert_window_ack_R11: assert property (@(posedge clk) disable iff (!rstN)
    mgmtAck && !singleMode |-> $past(mgmtReq));
endmodule

bind mgmt_window win_checker uChk (
  .clk(clk), .rstN(rstN), .mgmtReq(mgmtReq), .mgmtWrite(mgmtWrite),
  .mgmtDev(mgmtDev), .mgmtReg(mgmtReg), .mgmtAck(mgmtAck), .mgmtHit(mgmtHit),
  .mgmtRdata(mgmtRdata), .intReq(intReq), .intWrite(intWrite), .intDev(intDev),
  .intReg(intReg), .intWdata(intWdata), .intAck(intAck), .intRdata(intRdata),
  .busy(busy), .singleMode(singleMode), .strapLoaded(strapLoaded),
  .strapQ(strapQ), .cmdQ(cmdQ), .dataQ(dataQ)
);

// File: tb/tb_mgmt_window.sv
module tb_mgmt_window;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 8;
  localparam int WATCHDOG   = 50000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  strap = 4'd0;
  logic        mgmtReq = 1'b0, mgmtWrite = 1'b0;
  logic [4:0]  mgmtDev = '0, mgmtReg = '0;
  logic [15:0] mgmtWdata = '0;
  logic        mgmtAck, mgmtHit;
  logic [15:0] mgmtRdata;
  logic        intReq, intWrite;
  logic [4:0]  intDev, intReg;
  logic [15:0] intWdata;
  logic        intAck = 1'b0;
  logic [15:0] intRdata = '0;

  int checks = 0;
  int fails = 0;
  int startCnt = 0;
  logic [15:0] mem [32][32];

  typedef struct {
    logic        hit;
    logic [15:0] data;
    string       tag;
  } exp_t;
  exp_t expQ[$];

  mgmt_window dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mkCmd(input logic go, input logic md, input logic [1:0] op,
                                        input logic [4:0] dv, input logic [4:0] rg);
    return {go, 2'b00, md, op, dv, rg};
  endfunction

  // Internal register space model
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && intReq) begin
        logic [4:0]  d;
        logic [4:0]  r;
        logic        w;
        logic [15:0] wd;
        d = intDev; r = intReg; w = intWrite; wd = intWdata;
        startCnt++;
        repeat (LAT - 1) @(negedge clk);
        if (w) mem[d][r] = wd;
        intRdata = mem[d][r];
        intAck = 1'b1;
        @(negedge clk);
        intAck = 1'b0;
      end
    end
  end

  // Monitor: compare every response with the scoreboard
  always @(negedge clk) begin
    if (rstN && mgmtAck) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R11 unexpected ack", {15'd0, mgmtHit, mgmtRdata}, 32'd0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(mgmtHit == e.hit && mgmtRdata == e.data, e.tag,
              {15'd0, mgmtHit, mgmtRdata}, {15'd0, e.hit, e.data});
      end
    end
  end

  task automatic access(input logic wr, input logic [4:0] dv, input logic [4:0] rg,
                        input logic [15:0] wd, input logic expHit, input logic [15:0] expData,
                        input string tag, input logic oneCycle);
    exp_t e;
    e.hit = expHit; e.data = expData; e.tag = tag;
    expQ.push_back(e);
    @(negedge clk);
    mgmtReq = 1'b1; mgmtWrite = wr; mgmtDev = dv; mgmtReg = rg; mgmtWdata = wd;
    @(negedge clk);
    mgmtReq = 1'b0;
    if (oneCycle) begin
      check(mgmtAck == 1'b1, "R11 ack one cycle after request", {31'd0, mgmtAck}, 32'd1);
    end else begin
      for (int i = 0; i < 100 && !mgmtAck; i++) @(negedge clk);
    end
  endtask

  task automatic resetDut(input logic [3:0] s);
    @(negedge clk);
    rstN = 1'b0; strap = s;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(mgmtAck == 1'b0 && intReq == 1'b0, "R10 reset state idle",
          {30'd0, mgmtAck, intReq}, 32'd0);
  endtask

  initial begin
    for (int d = 0; d < 32; d++)
      for (int r = 0; r < 32; r++)
        mem[d][r] = 16'(d * 256 + r);
    mem[6][2] = 16'hBEEF;
    mem[7][3] = 16'h0000;
    mem[0][1] = 16'h4321;
    mem[17][2] = 16'h2222;

    // ---------- single-chip mode ----------
    resetDut(4'd0);
    strap = 4'd5;  // R1: ignored once captured
    access(1'b1, 5'd3, 5'd7, 16'hA5A5, 1'b1, 16'h0000, "R2 direct write ack", 1'b0);
    check(mem[3][7] == 16'hA5A5, "R2 direct write reached device 3 reg 7", {16'd0, mem[3][7]}, 32'hA5A5);
    access(1'b0, 5'd3, 5'd7, 16'h0, 1'b1, 16'hA5A5, "R2 direct read back", 1'b0);
    access(1'b1, 5'd31, 5'd31, 16'h0F0F, 1'b1, 16'h0000, "R2 direct write top address", 1'b0);
    access(1'b0, 5'd31, 5'd31, 16'h0, 1'b1, 16'h0F0F, "R2 direct read top address", 1'b0);
    access(1'b0, 5'd0, 5'd1, 16'h0, 1'b1, 16'h4321, "R2 direct read device 0", 1'b0);
    access(1'b0, 5'd17, 5'd2, 16'h0, 1'b1, 16'h2222, "R1 strap change after reset ignored", 1'b0);
    access(1'b0, 5'd20, 5'd20, 16'h0, 1'b1, 16'h1414, "R2 direct read high register", 1'b0);
    check(startCnt == 7, "R2 one internal access per management access", startCnt, 7);

    // ---------- multi-chip mode, strap 5 -> device 10 ----------
    resetDut(4'd5);
    strap = 4'd0;  // R1: must not fall back to single-chip mode
    startCnt = 0;
    access(1'b0, 5'd10, 5'd0, 16'h0, 1'b1, 16'h0000, "R10 command reset value", 1'b1);
    access(1'b0, 5'd10, 5'd1, 16'h0, 1'b1, 16'h0000, "R10 data reset value", 1'b1);
    access(1'b0, 5'd11, 5'd0, 16'h0, 1'b0, 16'hFFFF, "R3 odd neighbour not claimed", 1'b1);
    access(1'b0, 5'd0, 5'd0, 16'h0, 1'b0, 16'hFFFF, "R1 R3 device 0 not claimed after strap change", 1'b1);
    access(1'b0, 5'd10, 5'd2, 16'h0, 1'b0, 16'hFFFF, "R3 offset 2 not claimed", 1'b1);
    access(1'b1, 5'd12, 5'd1, 16'h7777, 1'b0, 16'hFFFF, "R3 foreign write not claimed", 1'b1);
    access(1'b1, 5'd10, 5'd3, 16'h7777, 1'b0, 16'hFFFF, "R3 offset 3 write not claimed", 1'b1);
    access(1'b0, 5'd10, 5'd1, 16'h0, 1'b1, 16'h0000, "R3 data register untouched by misses", 1'b1);
    check(startCnt == 0, "R3 misses start no internal access", startCnt, 0);

    access(1'b1, 5'd10, 5'd1, 16'h1234, 1'b1, 16'h0000, "R11 data write ack", 1'b1);
    access(1'b0, 5'd10, 5'd1, 16'h0, 1'b1, 16'h1234, "R7 data register holds value", 1'b1);
    access(1'b1, 5'd10, 5'd0, mkCmd(1, 1, 2'b01, 5'd4, 5'd9), 1'b1, 16'h0000, "R4 write command accepted", 1'b1);
    access(1'b0, 5'd10, 5'd0, 16'h0, 1'b1, 16'h9489, "R5 busy set during write command", 1'b1);
    repeat (12) @(negedge clk);
    access(1'b0, 5'd10, 5'd0, 16'h0, 1'b1, 16'h1489, "R5 busy cleared after write command", 1'b1);
    check(mem[4][9] == 16'h1234, "R7 data register sent to device 4 reg 9", {16'd0, mem[4][9]}, 32'h1234);
    check(startCnt == 1, "R5 one internal access per command", startCnt, 1);

    access(1'b1, 5'd10, 5'd0, mkCmd(1, 1, 2'b10, 5'd6, 5'd2), 1'b1, 16'h0000, "R4 read command accepted", 1'b1);
    access(1'b1, 5'd10, 5'd0, mkCmd(1, 1, 2'b01, 5'd7, 5'd3), 1'b1, 16'h0000, "R8 command while busy acked", 1'b1);
    access(1'b0, 5'd10, 5'd0, 16'h0, 1'b1, 16'h98C2, "R8 fields unchanged while busy", 1'b1);
    repeat (12) @(negedge clk);
    access(1'b0, 5'd10, 5'd0, 16'h0, 1'b1, 16'h18C2, "R5 busy cleared after read command", 1'b1);
    access(1'b0, 5'd10, 5'd1, 16'h0, 1'b1, 16'hBEEF, "R6 read result in data register", 1'b1);
    check(mem[7][3] == 16'h0000, "R8 ignored command did not write", {16'd0, mem[7][3]}, 32'h0);
    check(startCnt == 2, "R8 no extra internal access", startCnt, 2);

    access(1'b1, 5'd10, 5'd0, mkCmd(1, 0, 2'b10, 5'd6, 5'd2), 1'b1, 16'h0000, "R9 mode 0 write acked", 1'b1);
    access(1'b0, 5'd10, 5'd0, 16'h0, 1'b1, 16'h18C2, "R9 mode 0 command ignored", 1'b1);
    access(1'b1, 5'd10, 5'd0, mkCmd(1, 1, 2'b11, 5'd6, 5'd2), 1'b1, 16'h0000, "R9 opcode 11 write acked", 1'b1);
    access(1'b0, 5'd10, 5'd0, 16'h0, 1'b1, 16'h18C2, "R9 opcode 11 command ignored", 1'b1);
    access(1'b1, 5'd10, 5'd0, mkCmd(1, 1, 2'b00, 5'd6, 5'd2), 1'b1, 16'h0000, "R9 opcode 00 write acked", 1'b1);
    access(1'b0, 5'd10, 5'd0, 16'h0, 1'b1, 16'h18C2, "R9 opcode 00 command ignored", 1'b1);
    access(1'b1, 5'd10, 5'd0, mkCmd(0, 1, 2'b10, 5'd5, 5'd5), 1'b1, 16'h0000, "R9 start clear write acked", 1'b1);
    access(1'b0, 5'd10, 5'd0, 16'h0, 1'b1, 16'h18C2, "R9 start clear command ignored", 1'b1);
    repeat (12) @(negedge clk);
    check(startCnt == 2, "R9 invalid commands start no access", startCnt, 2);
    check(expQ.size() == 0, "R11 every access answered", expQ.size(), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule